// File: doc/BRIEF.md
# Pad Tower Coincidence Band Selector

This block sits in the pad trigger path of one detector sector. Every bunch crossing it receives one hit bit for every pad on each of eight pad layers. The layers form two quads of four layers each. Pads on odd layers are shifted by half a pad along the radial (eta) direction, so the block first forms logical towers half a pad wide. A tower fires when at least three of its four overlapping pads are hit in each quad, and both quads must pass. The towers are split into three radial regions. In each region the block picks at most one firing tower and reports its band (eta tower) index, its phi index and the BCID of the crossing. The strip readout uses this to fetch only the relevant band of strips.

The block takes a new crossing on every clock and has no back-pressure. A trigger path of fixed latency cannot pause, so there is no ready signal. The per-region valid bit qualifies each result, and a consumer must accept every cycle. A per-layer dead mask lets a broken layer count as always hit, so one failed layer does not block the majority.

Top module: `pad_tower_band_select`

## Requirements
- R1: `pad_hits` bit `layer*12 + phi*6 + pad` is the hit of pad `pad` (0..5) in phi column `phi` (0..1) of layer `layer` (0..7). Layers 0..3 form quad A and layers 4..7 form quad B.
- R2: Tower `t` (0..11) covers pad `t>>1` on even layers and pad `(t-1)>>1` on odd layers. Odd layers have no pad in tower 0.
- R3: A tower fires only if at least 3 of its 4 quad A layers and at least 3 of its 4 quad B layers are hit. One quad alone, or 2 of 4 in either quad, gives no coincidence.
- R4: A layer whose `layer_dead` bit is 1 counts as hit in every tower, whether or not it has a pad there.
- R5: Towers 0..3 form region 0 (inner), 4..7 form region 1 (middle) and 8..11 form region 2 (outer). Each region reports at most one tower per crossing, and its band always lies inside that region's range.
- R6: When several towers fire in a region, the lowest band wins. Within that band, phi 0 wins over phi 1.
- R7: Region `r` reports the global tower index in `out_band[4r+3:4r]` and the phi column in `out_phi[r]`.
- R8: `out_bcid[12r+11:12r]` carries the `bcid` value that came with the crossing that produced the coincidence.
- R9: Results appear two clock edges after the crossing is sampled. Back-to-back crossings are each reported in turn, without stalling.
- R10: A region with no coincidence drives valid, band, phi and BCID to zero.
- R11: A synchronous active-high `rst` clears all outputs at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch crossing clock |
| rst | input | 1 | Synchronous reset, active high |
| pad_hits | input | 96 | One hit bit per pad for all eight layers (R1 layout) |
| bcid | input | 12 | Crossing identifier for the current pad bits |
| layer_dead | input | 8 | Per-layer mask; a set bit forces that layer to count as hit |
| out_valid | output | 3 | Per-region coincidence found |
| out_band | output | 12 | Per-region band (tower) index, 4 bits per region |
| out_phi | output | 3 | Per-region phi column, 1 bit per region |
| out_bcid | output | 36 | Per-region BCID, 12 bits per region |

## Verification
The tests use full eight-layer towers and exact 3-of-4 patterns in each quad. These are compared with patterns that are 2-of-4 in one quad or that hit one quad only, which separates the per-quad majority from a plain total count. Pads set at a single staggered position show that the half-pad offset on odd layers picks exactly one tower, and patterns on tower 0 with dead layers show how the dead mask feeds into the majority. Several towers firing in one region, together with all layers dead, exercise the priority order. Crossings sent back to back with distinct BCIDs, and a reset in the middle of the stream, test the fixed latency and the BCID tagging.

// File: rtl/pt_pkg.sv
package pt_pkg;
  localparam int NUM_LAYERS  = 8;
  localparam int QUAD_LAYERS = 4;
  localparam int NUM_REGIONS = 3;
  localparam int MAJORITY    = 3;
endpackage

// File: rtl/pt_quad_majority.sv
module pt_quad_majority
  import pt_pkg::*;
(
  input  logic [QUAD_LAYERS-1:0] votes,
  output logic                   passed
);
  logic [2:0] tally;

  always_comb begin
    tally = '0;
    for (int i = 0; i < QUAD_LAYERS; i++) tally = tally + 3'(votes[i]);
    passed = (tally >= 3'(MAJORITY));
  end
endmodule

// File: rtl/pt_tower_grid.sv
module pt_tower_grid
  import pt_pkg::*;
#(
  parameter int ETA_PADS = 6,
  parameter int PHI_PADS = 2,
  localparam int LAYER_PADS = ETA_PADS * PHI_PADS,
  localparam int ETA_TOWERS = 2 * ETA_PADS
) (
  input  logic [NUM_LAYERS*LAYER_PADS-1:0] pad_hits,
  input  logic [NUM_LAYERS-1:0]            layer_dead,
  output logic [ETA_TOWERS*PHI_PADS-1:0]   tower_fire
);
  // tower_fire index = eta_tower * PHI_PADS + phi : lowest index = lowest band first
  for (genvar ph = 0; ph < PHI_PADS; ph++) begin : g_phi
    for (genvar t = 0; t < ETA_TOWERS; t++) begin : g_eta
      logic [NUM_LAYERS-1:0] lanes;
      logic                  quad_a_ok, quad_b_ok;

      for (genvar l = 0; l < NUM_LAYERS; l++) begin : g_lay
        if (l % 2 == 0) begin : g_even
          assign lanes[l] = pad_hits[l*LAYER_PADS + ph*ETA_PADS + (t >> 1)] | layer_dead[l];
        end else if (t == 0) begin : g_edge
          assign lanes[l] = layer_dead[l];
        end else begin : g_odd
          assign lanes[l] = pad_hits[l*LAYER_PADS + ph*ETA_PADS + ((t - 1) >> 1)] | layer_dead[l];
        end
      end

      pt_quad_majority u_quad_a (
        .votes  (lanes[QUAD_LAYERS-1:0]),
        .passed (quad_a_ok)
      );
      pt_quad_majority u_quad_b (
        .votes  (lanes[NUM_LAYERS-1:QUAD_LAYERS]),
        .passed (quad_b_ok)
      );

      assign tower_fire[t*PHI_PADS + ph] = quad_a_ok & quad_b_ok;
    end
  end
endmodule

// File: rtl/pt_region_picker.sv
module pt_region_picker #(
  parameter int REG_IDX    = 0,
  parameter int REG_TOWERS = 4,
  parameter int PHI_PADS   = 2,
  parameter int BAND_W     = 4,
  parameter int PHI_W      = 1,
  parameter int BCID_W     = 12,
  localparam int CANDS = REG_TOWERS * PHI_PADS,
  localparam int SEL_W = (CANDS > 1) ? $clog2(CANDS) : 1,
  localparam int BASE  = REG_IDX * REG_TOWERS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CANDS-1:0]  fire,
  input  logic [BCID_W-1:0] bcid_in,
  output logic              valid_o,
  output logic [BAND_W-1:0] band_o,
  output logic [PHI_W-1:0]  phi_o,
  output logic [BCID_W-1:0] bcid_o
);
  logic             found;
  logic [SEL_W-1:0] sel;

  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int i = CANDS - 1; i >= 0; i--) begin
      if (fire[i]) begin
        found = 1'b1;
        sel   = SEL_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !found) begin
      valid_o <= 1'b0;
      band_o  <= '0;
      phi_o   <= '0;
      bcid_o  <= '0;
    end else begin
      valid_o <= 1'b1;
      band_o  <= BAND_W'(BASE) + BAND_W'(int'(sel) / PHI_PADS);
      phi_o   <= PHI_W'(int'(sel) % PHI_PADS);
      bcid_o  <= bcid_in;
    end
  end

  // Candidate index rebuilt from the registered outputs, for the checks below
  int               out_sel;
  logic [CANDS-1:0] below_mask;
  always_comb begin
    out_sel    = (int'(band_o) - BASE) * PHI_PADS + int'(phi_o);
    below_mask = '0;
    for (int i = 0; i < CANDS; i++) if (i < out_sel) below_mask[i] = 1'b1;
  end

  assert_idle_zero_R10: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> (band_o == '0 && phi_o == '0 && bcid_o == '0));

  assert_band_in_region_R5: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> (int'(band_o) >= BASE && int'(band_o) < BASE + REG_TOWERS));

  assert_winner_fired_R6: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> ((($past(fire) >> out_sel) & CANDS'(1)) != '0));

  assert_no_lower_fired_R6: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> (($past(fire) & below_mask) == '0));
endmodule

// File: rtl/pad_tower_band_select.sv
module pad_tower_band_select
  import pt_pkg::*;
#(
  parameter int ETA_PADS = 6,
  parameter int PHI_PADS = 2,
  parameter int BCID_W   = 12,
  localparam int LAYER_PADS = ETA_PADS * PHI_PADS,
  localparam int ETA_TOWERS = 2 * ETA_PADS,
  localparam int REG_TOWERS = ETA_TOWERS / NUM_REGIONS,
  localparam int BAND_W     = $clog2(ETA_TOWERS),
  localparam int PHI_W      = (PHI_PADS > 1) ? $clog2(PHI_PADS) : 1,
  localparam int TOWERS     = ETA_TOWERS * PHI_PADS
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_LAYERS*LAYER_PADS-1:0] pad_hits,
  input  logic [BCID_W-1:0]             bcid,
  input  logic [NUM_LAYERS-1:0]         layer_dead,
  output logic [NUM_REGIONS-1:0]        out_valid,
  output logic [NUM_REGIONS*BAND_W-1:0] out_band,
  output logic [NUM_REGIONS*PHI_W-1:0]  out_phi,
  output logic [NUM_REGIONS*BCID_W-1:0] out_bcid
);
  logic [TOWERS-1:0] fire_now;
  logic [TOWERS-1:0] fire_q;
  logic [BCID_W-1:0] bcid_q;

  pt_tower_grid #(
    .ETA_PADS (ETA_PADS),
    .PHI_PADS (PHI_PADS)
  ) u_grid (
    .pad_hits   (pad_hits),
    .layer_dead (layer_dead),
    .tower_fire (fire_now)
  );

  // Stage 1: coincidence map and crossing tag
  always_ff @(posedge clk) begin
    if (rst) begin
      fire_q <= '0;
      bcid_q <= '0;
    end else begin
      fire_q <= fire_now;
      bcid_q <= bcid;
    end
  end

  // Stage 2: one registered picker per radial region
  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
    pt_region_picker #(
      .REG_IDX    (r),
      .REG_TOWERS (REG_TOWERS),
      .PHI_PADS   (PHI_PADS),
      .BAND_W     (BAND_W),
      .PHI_W      (PHI_W),
      .BCID_W     (BCID_W)
    ) u_pick (
      .clk     (clk),
      .rst     (rst),
      .fire    (fire_q[r*REG_TOWERS*PHI_PADS +: REG_TOWERS*PHI_PADS]),
      .bcid_in (bcid_q),
      .valid_o (out_valid[r]),
      .band_o  (out_band[r*BAND_W +: BAND_W]),
      .phi_o   (out_phi[r*PHI_W +: PHI_W]),
      .bcid_o  (out_bcid[r*BCID_W +: BCID_W])
    );

    assert_bcid_tag_R8: assert property (@(posedge clk) disable iff (rst)
      out_valid[r] |-> (out_bcid[r*BCID_W +: BCID_W] == $past(bcid, 2)));
  end

  assert_reset_clears_R11: assert property (@(posedge clk)
    $past(rst) |-> (out_valid == '0 && out_band == '0 && out_phi == '0 && out_bcid == '0));

  assert_latency_source_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid != '0) |-> ($past(pad_hits, 2) != '0 || $past(layer_dead, 2) != '0));
endmodule

// File: tb/pad_tower_band_select_bench.sv
module pad_tower_band_select_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [95:0] pad_hits = '0;
  logic [11:0] bcid = '0;
  logic [7:0]  layer_dead = '0;
  logic [2:0]  out_valid;
  logic [11:0] out_band;
  logic [2:0]  out_phi;
  logic [35:0] out_bcid;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pad_tower_band_select u_pad_tower_band_select (
    .clk (clk), .rst (rst), .pad_hits (pad_hits), .bcid (bcid),
    .layer_dead (layer_dead), .out_valid (out_valid), .out_band (out_band),
    .out_phi (out_phi), .out_bcid (out_bcid)
  );

  // ---- reference model from the requirements ----
  function automatic bit lane_hit(logic [95:0] p, logic [7:0] d, int l, int ph, int t);
    int pad;
    if (d[l]) return 1'b1;                       // R4
    if (l % 2 == 0) pad = t / 2;                 // R2
    else if (t == 0) return 1'b0;
    else pad = (t - 1) / 2;
    return p[l*12 + ph*6 + pad];                 // R1
  endfunction

  function automatic bit tower_on(logic [95:0] p, logic [7:0] d, int ph, int t);
    int a = 0, b = 0;
    for (int l = 0; l < 4; l++) a += lane_hit(p, d, l, ph, t);
    for (int l = 4; l < 8; l++) b += lane_hit(p, d, l, ph, t);
    return (a >= 3) && (b >= 3);                 // R3
  endfunction

  function automatic logic [95:0] tower_pads(int t, int ph, logic [7:0] layers);
    logic [95:0] v = '0;
    for (int l = 0; l < 8; l++) begin
      if (!layers[l]) continue;
      if (l % 2 == 0) v[l*12 + ph*6 + t/2] = 1'b1;
      else if (t > 0) v[l*12 + ph*6 + (t-1)/2] = 1'b1;
    end
    return v;
  endfunction

  task automatic check_now(logic [95:0] p, logic [7:0] d, logic [11:0] bc, string tag);
    for (int r = 0; r < 3; r++) begin
      logic ev = 0; logic [3:0] eb = 0; logic ep = 0; logic [11:0] ec = 0;
      for (int t = r*4; t < r*4 + 4 && !ev; t++)          // R5, R6
        for (int ph = 0; ph < 2 && !ev; ph++)
          if (tower_on(p, d, ph, t)) begin
            ev = 1; eb = 4'(t); ep = 1'(ph); ec = bc;
          end
      checks++;
      if (out_valid[r] !== ev || out_band[r*4 +: 4] !== eb ||
          out_phi[r] !== ep || out_bcid[r*12 +: 12] !== ec) begin
        fails++;
        $display("FAIL %s region %0d: got v=%0b band=%0d phi=%0d bcid=%0d, expected v=%0b band=%0d phi=%0d bcid=%0d",
                 tag, r, out_valid[r], out_band[r*4 +: 4], out_phi[r], out_bcid[r*12 +: 12],
                 ev, eb, ep, ec);
      end
    end
  endtask

  task automatic one_crossing(logic [95:0] p, logic [7:0] d, logic [11:0] bc, string tag);
    @(negedge clk); pad_hits = p; layer_dead = d; bcid = bc;
    @(negedge clk); pad_hits = '0; layer_dead = '0; bcid = '0;
    @(negedge clk); check_now(p, d, bc, tag);      // R9: two edges after sampling
  endtask

  // ---- scenarios ----
  task automatic t_reset;
    check_now('0, '0, '0, "R11 reset state");
  endtask

  task automatic t_full_tower;
    one_crossing(tower_pads(5, 1, 8'hFF), '0, 12'd77, "R7 full tower band5 phi1");
  endtask

  task automatic t_three_of_four;
    one_crossing(tower_pads(9, 0, 8'b0111_0111), '0, 12'd12, "R3 3-of-4 each quad");
  endtask

  task automatic t_two_of_four;
    one_crossing(tower_pads(2, 0, 8'b0011_0111), '0, 12'd13, "R10 R3 2-of-4 quad B no fire");
  endtask

  task automatic t_one_quad;
    one_crossing(tower_pads(6, 1, 8'b0000_1111), '0, 12'd14, "R3 quad A only");
  endtask

  task automatic t_stagger;
    one_crossing(tower_pads(5, 0, 8'hFF), '0, 12'd15, "R2 stagger selects tower5");
  endtask

  task automatic t_tower_zero;
    one_crossing(tower_pads(0, 0, 8'hFF), '0, 12'd16, "R2 tower0 no odd pads");
    one_crossing(tower_pads(0, 0, 8'hFF), 8'h22, 12'd17, "R4 tower0 with dead odd layers");
  endtask

  task automatic t_dead_mask;
    one_crossing(tower_pads(10, 1, 8'b0011_0011), 8'b1000_1000, 12'd18, "R4 dead layers 3 and 7");
  endtask

  task automatic t_priority;
    one_crossing(tower_pads(3, 0, 8'hFF) | tower_pads(2, 1, 8'hFF), '0, 12'd19,
                 "R6 lower band beats lower phi");
    one_crossing(tower_pads(6, 1, 8'hFF) | tower_pads(6, 0, 8'hFF), '0, 12'd20,
                 "R6 phi0 wins in same band");
  endtask

  task automatic t_all_regions;
    one_crossing(tower_pads(1, 1, 8'hFF) | tower_pads(7, 0, 8'hFF) | tower_pads(11, 1, 8'hFF),
                 '0, 12'd300, "R5 R8 all regions");
  endtask

  task automatic t_all_dead;
    one_crossing('0, 8'hFF, 12'd21, "R4 R6 all layers dead");
  endtask

  task automatic t_bcid_wrap;
    one_crossing(tower_pads(8, 0, 8'hFF), '0, 12'hFFF, "R8 max bcid");
  endtask

  task automatic t_pipeline;
    logic [95:0] p0 = tower_pads(1, 0, 8'hFF);
    logic [95:0] p1 = tower_pads(4, 1, 8'hFF);
    logic [95:0] p2 = tower_pads(11, 0, 8'hFF);
    @(negedge clk); pad_hits = p0; bcid = 12'd100;
    @(negedge clk); pad_hits = p1; bcid = 12'd101;
    @(negedge clk); check_now(p0, '0, 12'd100, "R9 back-to-back #0");
    pad_hits = p2; bcid = 12'd102;
    @(negedge clk); check_now(p1, '0, 12'd101, "R9 back-to-back #1");
    pad_hits = '0; bcid = '0;
    @(negedge clk); check_now(p2, '0, 12'd102, "R9 R8 back-to-back #2");
  endtask

  task automatic t_reset_mid;
    @(negedge clk); pad_hits = tower_pads(3, 0, 8'hFF); bcid = 12'd55;
    @(negedge clk); pad_hits = tower_pads(9, 1, 8'hFF); rst = 1'b1;
    @(negedge clk); check_now('0, '0, '0, "R11 reset mid-stream");
    pad_hits = '0; bcid = '0; rst = 1'b0;
    @(negedge clk);
    @(negedge clk); check_now('0, '0, '0, "R11 quiet after reset");
  endtask

  task automatic finish_run;
    if (done) return;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_full_tower();
    t_three_of_four();
    t_two_of_four();
    t_one_quad();
    t_stagger();
    t_tower_zero();
    t_dead_mask();
    t_priority();
    t_all_regions();
    t_all_dead();
    t_bcid_wrap();
    t_pipeline();
    t_reset_mid();
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, got timeout, expected completion");
      finish_run();
    end
  end
endmodule